// File: doc/BRIEF.md
# Hybrid incremental/cyclic ADC digital backend

This block is the digital half of a two-stage converter. One shared integrator and one three-level comparator are first run as an incremental sigma-delta modulator and then as a cyclic converter. The block sequences one conversion and turns the comparator decisions into a 14-bit output code. A start request begins a fixed schedule: a short integrator reset phase, a long counting phase and then a short cyclic phase. The block drives the phase and mode controls of the analog stage.

In the counting phase, an accumulator acts as the decimation filter. It counts the high decisions at full weight and the middle decisions at half weight. In the cyclic phase, the decisions are redundant signed digits and are folded MSB-first into a signed word. The two partial results overlap by one bit. They are summed and clamped into the unsigned output range. The finished code is held as a parallel word, and it is also shifted out serially with a frame-valid flag.

Top module: `hybrid_adc_backend`

## Requirements
- R1: After an accepted start, `busy_o` is high for 265 cycles. `rst_phase_o` is high for the first 2 of them. `cyc_mode_o` is low for the next 256 cycles (incremental mode, integrator gain 0.5) and high for the final 7 (cyclic mode, gain 1).
- R2: A start request that arrives while `busy_o` is high has no effect on the schedule or on the result.
- R3: Decision codes are 00 (below −Vref/4), 01 (between the thresholds) and 10 (above +Vref/4). Over the 256 incremental cycles, the filter value is F = 2·N10 + N01, which equals twice N10 + N01/2.
- R4: In the cyclic phase, each decision is a signed digit: 00 → −1, 01 → 0, 10 → +1. The signed cyclic value S is built MSB-first by repeating S ← 2·S + digit over the 7 digits.
- R5: `integ_en_o` is low when idle, during the reset phase and in the first cyclic cycle, where the residue is only quantized. It is high in every other busy cycle.
- R6: The output code is F·32 + S (the incremental result weighted by 2^(M−1) = 64, plus S), clamped to the range 0 to 16383.
- R7: `done_o` is high for exactly one cycle, the cycle after the last cyclic decision, and `busy_o` is low in that cycle. `result_o` takes the new code in that same cycle and otherwise holds its value.
- R8: The serial output starts in the cycle in which `done_o` is high. `ser_o` carries the code MSB first, one bit per clock, while `ser_valid_o` is high for exactly 14 clocks.
- R9: While `rst_ni` is low, `busy_o`, `done_o`, `ser_valid_o`, `ser_o`, `rst_phase_o`, `cyc_mode_o` and `integ_en_o` are all 0, and `result_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled only when idle |
| dec_i | input | 2 | Three-level comparator decision |
| rst_phase_o | output | 1 | Integrator reset phase |
| cyc_mode_o | output | 1 | 0 incremental (gain 0.5), 1 cyclic (gain 1) |
| integ_en_o | output | 1 | Integrate this cycle |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 14 | Latched output code |
| ser_o | output | 1 | Serial code, MSB first |
| ser_valid_o | output | 1 | Serial frame valid |

## Verification
The assertions assume that the comparator never returns the unused code 11 during the counting or cyclic phases. They also assume that decisions are stable around each rising edge. The bench drives `dec_i` only on falling edges. It takes every code either from fixed patterns or from a behavioural residue loop whose quantizer can only yield 00, 01 or 10. Outside those phases, the bench holds the decision at 01.

// File: rtl/hyb_adc_pkg.sv
package hyb_adc_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_RST, PH_INC, PH_CYC} phase_e;

  localparam logic [1:0] DEC_LO  = 2'b00;
  localparam logic [1:0] DEC_MID = 2'b01;
  localparam logic [1:0] DEC_HI  = 2'b10;

  function automatic logic signed [1:0] dec_digit(input logic [1:0] d);
    case (d)
      DEC_LO:  dec_digit = -2'sd1;
      DEC_HI:  dec_digit = 2'sd1;
      default: dec_digit = 2'sd0;
    endcase
  endfunction
endpackage

// File: rtl/hyb_adc_seq.sv
module hyb_adc_seq
  import hyb_adc_pkg::*;
#(
  parameter int RST_CYC = 2,
  parameter int INC_CYC = 256,
  parameter int CYC_CYC = 7,
  parameter int CNT_W   = 9
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  output phase_e phase_o,
  output logic   first_cyc_o,
  output logic   accept_o,
  output logic   last_o
);
  phase_e            ph_q;
  logic [CNT_W-1:0]  cnt_q;

  assign accept_o    = (ph_q == PH_IDLE) && start_i;
  assign last_o      = (ph_q == PH_CYC) && (cnt_q == CNT_W'(CYC_CYC - 1));
  assign first_cyc_o = (ph_q == PH_CYC) && (cnt_q == '0);
  assign phase_o     = ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: if (start_i) begin
          ph_q  <= PH_RST;
          cnt_q <= '0;
        end
        PH_RST: if (cnt_q == CNT_W'(RST_CYC - 1)) begin
          ph_q  <= PH_INC;
          cnt_q <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        PH_INC: if (cnt_q == CNT_W'(INC_CYC - 1)) begin
          ph_q  <= PH_CYC;
          cnt_q <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        PH_CYC: if (last_o) begin
          ph_q  <= PH_IDLE;
          cnt_q <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hyb_adc_inc_filt.sv
module hyb_adc_inc_filt
  import hyb_adc_pkg::*;
#(
  parameter int F_W = 10
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           en_i,
  input  logic [1:0]     dec_i,
  output logic [F_W-1:0] filt_o
);
  logic [F_W-1:0] acc_q;

  // high decisions weigh 2, middle weigh 1: twice the half-weighted count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       acc_q <= '0;
    else if (clr_i)    acc_q <= '0;
    else if (en_i) begin
      if (dec_i == DEC_HI)       acc_q <= acc_q + F_W'(2);
      else if (dec_i == DEC_MID) acc_q <= acc_q + F_W'(1);
    end
  end

  assign filt_o = acc_q;
endmodule

// File: rtl/hyb_adc_rsd_merge.sv
module hyb_adc_rsd_merge
  import hyb_adc_pkg::*;
#(
  parameter int M_CYC  = 7,
  parameter int F_W    = 10,
  parameter int CODE_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [1:0]        dec_i,
  input  logic [F_W-1:0]    filt_i,
  output logic [CODE_W-1:0] code_o
);
  localparam int S_W   = M_CYC + 1;
  localparam int RAW_W = CODE_W + 3;
  localparam logic signed [RAW_W-1:0] CODE_MAX = RAW_W'((1 << CODE_W) - 1);

  logic signed [S_W-1:0]   s_q, s_nxt;
  logic signed [RAW_W-1:0] inc_term, cyc_term, raw;

  assign s_nxt = (s_q <<< 1) + S_W'(dec_digit(dec_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    s_q <= '0;
    else if (clr_i) s_q <= '0;
    else if (en_i)  s_q <= s_nxt;
  end

  // value including the digit presented this cycle
  always_comb begin
    inc_term = $signed(RAW_W'(filt_i)) <<< (M_CYC - 2);
    cyc_term = RAW_W'(s_nxt);
    raw      = inc_term + cyc_term;
    if (raw < 0)             code_o = '0;
    else if (raw > CODE_MAX) code_o = CODE_MAX[CODE_W-1:0];
    else                     code_o = raw[CODE_W-1:0];
  end
endmodule

// File: rtl/hyb_adc_p2s.sv
module hyb_adc_p2s #(
  parameter int CODE_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CODE_W-1:0] word_i,
  output logic              ser_o,
  output logic              valid_o
);
  localparam int C_W = $clog2(CODE_W + 1);

  logic [CODE_W-1:0] sh_q;
  logic [C_W-1:0]    left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (load_i) begin
      sh_q   <= word_i;
      left_q <= C_W'(CODE_W);
    end else if (left_q != '0) begin
      sh_q   <= sh_q << 1;
      left_q <= left_q - 1'b1;
    end
  end

  assign ser_o   = (left_q != '0) & sh_q[CODE_W-1];
  assign valid_o = (left_q != '0);
endmodule

// File: rtl/hybrid_adc_backend.sv
module hybrid_adc_backend
  import hyb_adc_pkg::*;
#(
  parameter int N_INC   = 8,
  parameter int M_CYC   = 7,
  parameter int RST_CYC = 2,
  parameter int CODE_W  = N_INC + M_CYC - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        dec_i,
  output logic              rst_phase_o,
  output logic              cyc_mode_o,
  output logic              integ_en_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [CODE_W-1:0] result_o,
  output logic              ser_o,
  output logic              ser_valid_o
);
  localparam int INC_CYC = 1 << N_INC;
  localparam int CNT_W   = N_INC + 1;
  localparam int F_W     = N_INC + 2;

  phase_e            phase;
  logic              first_cyc, accept, last;
  logic [F_W-1:0]    filt;
  logic [CODE_W-1:0] code;
  logic              done_q;
  logic [CODE_W-1:0] res_q;

  hyb_adc_seq #(
    .RST_CYC(RST_CYC), .INC_CYC(INC_CYC), .CYC_CYC(M_CYC), .CNT_W(CNT_W)
  ) u_seq (
    .clk_i, .rst_ni, .start_i,
    .phase_o(phase), .first_cyc_o(first_cyc), .accept_o(accept), .last_o(last)
  );

  hyb_adc_inc_filt #(.F_W(F_W)) u_filt (
    .clk_i, .rst_ni, .clr_i(accept), .en_i(phase == PH_INC),
    .dec_i, .filt_o(filt)
  );

  hyb_adc_rsd_merge #(.M_CYC(M_CYC), .F_W(F_W), .CODE_W(CODE_W)) u_merge (
    .clk_i, .rst_ni, .clr_i(accept), .en_i(phase == PH_CYC),
    .dec_i, .filt_i(filt), .code_o(code)
  );

  hyb_adc_p2s #(.CODE_W(CODE_W)) u_p2s (
    .clk_i, .rst_ni, .load_i(last), .word_i(code),
    .ser_o, .valid_o(ser_valid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      res_q  <= '0;
    end else begin
      done_q <= last;
      if (last) res_q <= code;
    end
  end

  assign rst_phase_o = (phase == PH_RST);
  assign cyc_mode_o  = (phase == PH_CYC);
  assign busy_o      = (phase != PH_IDLE);
  assign integ_en_o  = (phase == PH_INC) || ((phase == PH_CYC) && !first_cyc);
  assign done_o      = done_q;
  assign result_o    = res_q;
endmodule

// File: rtl/hybrid_adc_backend_chk.sv
module hybrid_adc_backend_chk #(
  parameter int CODE_W = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [1:0]        dec_i,
  input logic              rst_phase_o,
  input logic              cyc_mode_o,
  input logic              integ_en_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [CODE_W-1:0] result_o,
  input logic              ser_o,
  input logic              ser_valid_o
);
  // R1
  phase_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_phase_o || cyc_mode_o) |-> (busy_o && !(rst_phase_o && cyc_mode_o)));

  // R3
  dec_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !rst_phase_o) |-> (dec_i != 2'b11));

  // R5
  integ_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_phase_o || !busy_o) |-> !integ_en_o);

  // R5
  first_cyc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cyc_mode_o) |-> !integ_en_o);

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7
  done_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  // R7
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));

  // R8
  ser_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ser_valid_o) |-> done_o);

  // R8
  ser_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ser_valid_o |-> !ser_o);
endmodule

bind hybrid_adc_backend hybrid_adc_backend_chk #(.CODE_W(CODE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .dec_i(dec_i),
  .rst_phase_o(rst_phase_o), .cyc_mode_o(cyc_mode_o), .integ_en_o(integ_en_o),
  .busy_o(busy_o), .done_o(done_o), .result_o(result_o), .ser_o(ser_o),
  .ser_valid_o(ser_valid_o)
);

// File: tb/tb_hybrid_adc_backend.sv
`timescale 1ns/1ps
module tb_hybrid_adc_backend;
  localparam int W = 14;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [1:0]   dec_i = 2'b01;
  logic         rst_phase_o, cyc_mode_o, integ_en_o, busy_o, done_o;
  logic [W-1:0] result_o;
  logic         ser_o, ser_valid_o;

  int total = 0;
  int bad = 0;

  logic [1:0] inc_d [256];
  logic [1:0] cyc_d [7];

  always #5 clk_i = ~clk_i;

  hybrid_adc_backend dut (
    .clk_i, .rst_ni, .start_i, .dec_i, .rst_phase_o, .cyc_mode_o,
    .integ_en_o, .busy_o, .done_o, .result_o, .ser_o, .ser_valid_o
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int expect_code();
    int f = 0;
    int s = 0;
    int raw;
    for (int i = 0; i < 256; i++)
      f += (inc_d[i] == 2'b10) ? 2 : (inc_d[i] == 2'b01) ? 1 : 0;
    for (int k = 0; k < 7; k++)
      s = 2 * s + ((cyc_d[k] == 2'b10) ? 1 : (cyc_d[k] == 2'b00) ? -1 : 0);
    raw = f * 32 + s;
    if (raw < 0) raw = 0;
    if (raw > 16383) raw = 16383;
    return raw;
  endfunction

  // one conversion; mid_start pulses start while busy
  task automatic run_conv(input string name, input bit mid_start);
    int exp = expect_code();
    int sw = 0;
    @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(rst_phase_o && busy_o && !integ_en_o, {name, " R1 rst phase 1"}, rst_phase_o, 1);
    @(negedge clk_i);
    chk(rst_phase_o && !cyc_mode_o, {name, " R1 rst phase 2"}, rst_phase_o, 1);
    @(negedge clk_i);
    chk(!rst_phase_o && !cyc_mode_o && integ_en_o, {name, " R1/R5 inc entry"}, cyc_mode_o, 0);
    for (int i = 0; i < 256; i++) begin
      dec_i = inc_d[i];
      start_i = mid_start && (i == 100 || i == 255);
      @(negedge clk_i);
    end
    start_i = 1'b0;
    chk(cyc_mode_o && busy_o && !integ_en_o, {name, " R1/R5 cyc entry"}, integ_en_o, 0);
    for (int k = 0; k < 7; k++) begin
      dec_i = cyc_d[k];
      if (k > 0) chk(integ_en_o && cyc_mode_o, {name, " R5 cyc integ"}, integ_en_o, 1);
      if (k == 3 && mid_start) start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    dec_i = 2'b01;
    chk(done_o && !busy_o, {name, " R7 done"}, done_o, 1);
    chk(result_o == W'(exp), {name, " R6 code"}, int'(result_o), exp);
    chk(ser_valid_o, {name, " R8 valid start"}, ser_valid_o, 1);
    sw = ser_o;
    for (int b = 1; b < W; b++) begin
      @(negedge clk_i);
      if (b == 1) chk(!done_o, {name, " R7 done one cycle"}, done_o, 0);
      chk(ser_valid_o, {name, " R8 valid held"}, ser_valid_o, 1);
      sw = (sw << 1) | ser_o;
    end
    @(negedge clk_i);
    chk(!ser_valid_o, {name, " R8 valid 14 clocks"}, ser_valid_o, 0);
    chk(sw == exp, {name, " R8 serial word"}, sw, exp);
    chk(result_o == W'(exp), {name, " R7 result held"}, int'(result_o), exp);
    chk(!busy_o, {name, " R2 idle after"}, busy_o, 0);
  endtask

  task automatic t_reset();
    chk(!busy_o && !done_o && !ser_valid_o && !ser_o && !rst_phase_o
        && !cyc_mode_o && !integ_en_o && result_o == '0, "R9 reset state",
        int'(result_o), 0);
  endtask

  task automatic t_mid();
    for (int i = 0; i < 256; i++) inc_d[i] = 2'b01;
    for (int k = 0; k < 7; k++) cyc_d[k] = 2'b01;
    run_conv("mid R3", 1'b0);  // F=256 -> 8192
  endtask

  task automatic t_top_clamp();
    for (int i = 0; i < 256; i++) inc_d[i] = 2'b10;
    for (int k = 0; k < 7; k++) cyc_d[k] = 2'b10;
    run_conv("top R6", 1'b0);  // 16384+127 clamps to 16383
  endtask

  task automatic t_bottom_clamp();
    for (int i = 0; i < 256; i++) inc_d[i] = 2'b00;
    for (int k = 0; k < 7; k++) cyc_d[k] = 2'b00;
    run_conv("bottom R6", 1'b0);  // -127 clamps to 0
  endtask

  task automatic t_pattern();
    for (int i = 0; i < 256; i++) inc_d[i] = (i < 100) ? 2'b10 : (i < 150) ? 2'b01 : 2'b00;
    cyc_d[0] = 2'b10; cyc_d[1] = 2'b00; cyc_d[2] = 2'b01; cyc_d[3] = 2'b10;
    cyc_d[4] = 2'b01; cyc_d[5] = 2'b01; cyc_d[6] = 2'b00;
    chk(expect_code() == 8039, "R4 digit weighting model", expect_code(), 8039);
    run_conv("pattern R4", 1'b0);
  endtask

  task automatic t_ignore_start();
    for (int i = 0; i < 256; i++) inc_d[i] = (i % 3 == 0) ? 2'b10 : 2'b01;
    for (int k = 0; k < 7; k++) cyc_d[k] = (k % 2 == 0) ? 2'b00 : 2'b10;
    run_conv("busy start R2", 1'b1);
  endtask

  // behavioural residue loop; vref = 65536, thresholds at +-16384
  task automatic t_loop(input int vin, input string name);
    int v = 0;
    int dac;
    logic [1:0] d;
    for (int i = 0; i < 256; i++) begin
      d = (v > 16384) ? 2'b10 : (v <= -16384) ? 2'b00 : 2'b01;
      dac = (d == 2'b10) ? 65536 : (d == 2'b00) ? -65536 : 0;
      inc_d[i] = d;
      v = v + (vin - dac) / 2;
    end
    for (int k = 0; k < 7; k++) begin
      d = (v > 16384) ? 2'b10 : (v <= -16384) ? 2'b00 : 2'b01;
      dac = (d == 2'b10) ? 65536 : (d == 2'b00) ? -65536 : 0;
      cyc_d[k] = d;
      v = 2 * v - dac;
    end
    run_conv(name, 1'b0);
  endtask

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_mid();
    t_top_clamp();
    t_bottom_clamp();
    t_pattern();
    t_ignore_start();
    t_loop(20000, "loop pos R3");
    t_loop(-31000, "loop neg R4");
    t_loop(777, "loop small R6");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule